// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small multicycle load/store processor. It holds a ten-word microcode store, addressed by a microprogram counter. In every cycle it decodes the current microword into strobes and multiplexer selects for the ALU, the two ALU operand paths, the register file, memory and the program counter. It also picks the address of the next microword.

Each microword carries its own sequencing code. That code says whether the next address is the current address plus one, a return to the instruction-fetch word at address 0, or a lookup in one of two opcode-indexed dispatch tables. The first table branches after decode to the memory, register-format, branch or jump routines. The second table splits loads from stores. If an opcode is missing from the table being consulted, the block flags it and returns to fetch.

The surrounding datapath places the 6-bit opcode from its instruction register on `opcode_i`. It then acts on the decoded controls. The ALU, the memory and the registers are not part of this block.

Top module: `ucode_sequencer`

## Requirements
- R1: Reset is synchronous and active low. After any rising clock edge at which `rst_n` is low, `upc_o` is 0 and the outputs show the fetch word.
- R2: Word 0 (fetch) drives `alu_op_o`=00 (add), `alu_src_a_o`=0 (PC), `alu_src_b_o`=01 (constant 4), `mem_read_o`=1, `mem_addr_sel_o`=0 (PC), `ir_write_o`=1, `pc_write_o`=1 and `pc_src_o`=00 (ALU result). Its successor is always word 1.
- R3: Word 1 (decode) drives `alu_op_o`=00, `alu_src_a_o`=0, `alu_src_b_o`=11 (shifted sign-extended immediate) and `rf_read_o`=1. Its successor comes from table 1: opcode 0x23 or 0x2B goes to word 2, 0x00 to word 6, 0x04 to word 8 and 0x02 to word 9.
- R4: Word 2 (address computation) drives `alu_op_o`=00, `alu_src_a_o`=1 (A), `alu_src_b_o`=10 (sign-extended immediate). Its successor comes from table 2: opcode 0x23 goes to word 3 and 0x2B to word 5.
- R5: The load tail has two words. Word 3 drives `mem_read_o`=1 with `mem_addr_sel_o`=1 (ALUout) and then moves to word 4. Word 4 drives `rf_write_o`=1 with `rf_wdata_sel_o`=1 (memory data) and then returns to word 0.
- R6: Word 5 (store) drives `mem_write_o`=1 with `mem_addr_sel_o`=1 and then returns to word 0.
- R7: Word 6 drives `alu_op_o`=10 (function field), `alu_src_a_o`=1 and `alu_src_b_o`=00 (B), then moves to word 7. Word 7 drives `rf_write_o`=1 with `rf_wdata_sel_o`=0 (ALUout) and then returns to word 0.
- R8: Word 8 (branch) drives `alu_op_o`=01 (subtract), `alu_src_a_o`=1, `alu_src_b_o`=00, `pc_write_cond_o`=1 and `pc_src_o`=01 (ALUout), then returns to word 0.
- R9: Word 9 (jump) drives `pc_write_o`=1 with `pc_src_o`=10 (jump address) and then returns to word 0.
- R10: In word 1 or word 2, an opcode absent from that word's table raises `illegal_opcode_o` in the same cycle and makes the next address 0. In every other word the opcode has no effect: `illegal_opcode_o` stays low and the sequence does not change.
- R11: A strobe not named for a word is 0. A select not named for a word is 0. No two of read/write on the register file, read/write on memory, or the two PC-write strobes are ever high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode_i | input | 6 | Opcode of the instruction being executed |
| upc_o | output | 4 | Current microaddress |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |
| alu_src_a_o | output | 1 | First operand: 0 PC, 1 register A |
| alu_src_b_o | output | 2 | Second operand: 00 B, 01 four, 10 immediate, 11 shifted immediate |
| rf_read_o | output | 1 | Read rs/rt into A and B |
| rf_write_o | output | 1 | Write register file |
| rf_wdata_sel_o | output | 1 | Write data: 0 ALUout, 1 memory data |
| mem_read_o | output | 1 | Memory read |
| mem_write_o | output | 1 | Memory write |
| mem_addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALUout |
| ir_write_o | output | 1 | Load instruction register |
| pc_write_o | output | 1 | Unconditional PC write |
| pc_write_cond_o | output | 1 | PC write when ALU zero is set |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALUout, 10 jump address |
| illegal_opcode_o | output | 1 | Opcode missing from the active dispatch table |

## Verification
The control outputs and `illegal_opcode_o` are combinational from the microaddress and the opcode, so they are due in the same cycle that an address or opcode appears. The next address, and a reset, take effect one rising edge later. The reference model updates its expected address once per clock, from the opcode it drove in that cycle. It compares all outputs at the falling edge, half a period after each change. In non-dispatch cycles the bench drives junk opcodes, so any leak of the opcode into those words shows up in the comparison.

// File: rtl/ucode_pkg.sv
// Package: field encodings and the microword layout shared by the
// sequencer, its sub-blocks and its checker. Assumes no datapath detail.
package ucode_pkg;

    typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNC = 2'b10} alu_f_e;
    typedef enum logic       {OPA_PC = 1'b0, OPA_REG = 1'b1} opa_f_e;
    typedef enum logic [1:0] {OPB_REG = 2'b00, OPB_FOUR = 2'b01, OPB_IMM = 2'b10, OPB_IMMSH = 2'b11} opb_f_e;
    typedef enum logic [1:0] {RFC_IDLE, RFC_READ, RFC_WR_ALU, RFC_WR_MEM} rfc_f_e;
    typedef enum logic [1:0] {MEMC_IDLE, MEMC_RD_PC, MEMC_RD_ALU, MEMC_WR_ALU} memc_f_e;
    typedef enum logic [1:0] {PCC_IDLE, PCC_ALU, PCC_COND, PCC_JUMP} pcc_f_e;
    typedef enum logic [1:0] {NXT_INC, NXT_FETCH, NXT_TBL1, NXT_TBL2} nxt_f_e;

    // One microword: six datapath fields plus the sequencing field.
    typedef struct packed {
        alu_f_e  alu;
        opa_f_e  opa;
        opb_f_e  opb;
        rfc_f_e  rfc;
        memc_f_e memc;
        pcc_f_e  pcc;
        nxt_f_e  nxt;
    } uword_t;

endpackage

// File: rtl/ucode_store.sv
// Microcode store: returns the microword at a given address.
// Assumes addresses 10 and above are never reached; they read as a
// quiet word that returns to fetch.
module ucode_store
    import ucode_pkg::*;
#(
    parameter int UA_W = 4
) (
    input  logic [UA_W-1:0] addr_i,
    output uword_t          word_o
);

    // Purpose: constant lookup of the ten-word microprogram.
    always_comb begin
        word_o = '{alu: ALU_ADD, opa: OPA_PC, opb: OPB_REG, rfc: RFC_IDLE,
                   memc: MEMC_IDLE, pcc: PCC_IDLE, nxt: NXT_FETCH};
        case (addr_i)
            UA_W'(0): word_o = '{ALU_ADD,  OPA_PC,  OPB_FOUR,  RFC_IDLE,   MEMC_RD_PC,  PCC_ALU,  NXT_INC};
            UA_W'(1): word_o = '{ALU_ADD,  OPA_PC,  OPB_IMMSH, RFC_READ,   MEMC_IDLE,   PCC_IDLE, NXT_TBL1};
            UA_W'(2): word_o = '{ALU_ADD,  OPA_REG, OPB_IMM,   RFC_IDLE,   MEMC_IDLE,   PCC_IDLE, NXT_TBL2};
            UA_W'(3): word_o = '{ALU_ADD,  OPA_PC,  OPB_REG,   RFC_IDLE,   MEMC_RD_ALU, PCC_IDLE, NXT_INC};
            UA_W'(4): word_o = '{ALU_ADD,  OPA_PC,  OPB_REG,   RFC_WR_MEM, MEMC_IDLE,   PCC_IDLE, NXT_FETCH};
            UA_W'(5): word_o = '{ALU_ADD,  OPA_PC,  OPB_REG,   RFC_IDLE,   MEMC_WR_ALU, PCC_IDLE, NXT_FETCH};
            UA_W'(6): word_o = '{ALU_FUNC, OPA_REG, OPB_REG,   RFC_IDLE,   MEMC_IDLE,   PCC_IDLE, NXT_INC};
            UA_W'(7): word_o = '{ALU_ADD,  OPA_PC,  OPB_REG,   RFC_WR_ALU, MEMC_IDLE,   PCC_IDLE, NXT_FETCH};
            UA_W'(8): word_o = '{ALU_SUB,  OPA_REG, OPB_REG,   RFC_IDLE,   MEMC_IDLE,   PCC_COND, NXT_FETCH};
            UA_W'(9): word_o = '{ALU_ADD,  OPA_PC,  OPB_REG,   RFC_IDLE,   MEMC_IDLE,   PCC_JUMP, NXT_FETCH};
            default: ;
        endcase
    end

endmodule

// File: rtl/ucode_dispatch.sv
// Dispatch tables: map the opcode to a routine entry for table 1
// (after decode) and table 2 (after address computation), each with a
// hit flag. Assumes entry addresses fit in UA_W bits.
module ucode_dispatch #(
    parameter int          OPC_W  = 6,
    parameter int          UA_W   = 4,
    parameter logic [5:0]  OP_LD  = 6'h23,
    parameter logic [5:0]  OP_ST  = 6'h2B,
    parameter logic [5:0]  OP_ALU = 6'h00,
    parameter logic [5:0]  OP_BR  = 6'h04,
    parameter logic [5:0]  OP_JMP = 6'h02
) (
    input  logic [OPC_W-1:0] opcode_i,
    output logic [UA_W-1:0]  t1_addr_o,
    output logic             t1_hit_o,
    output logic [UA_W-1:0]  t2_addr_o,
    output logic             t2_hit_o
);

    localparam logic [UA_W-1:0] E_MEM = UA_W'(2);
    localparam logic [UA_W-1:0] E_LD  = UA_W'(3);
    localparam logic [UA_W-1:0] E_ST  = UA_W'(5);
    localparam logic [UA_W-1:0] E_ALU = UA_W'(6);
    localparam logic [UA_W-1:0] E_BR  = UA_W'(8);
    localparam logic [UA_W-1:0] E_JMP = UA_W'(9);

    // Purpose: table 1 picks the instruction class routine.
    always_comb begin
        t1_hit_o  = 1'b1;
        t1_addr_o = '0;
        if (opcode_i == OPC_W'(OP_LD) || opcode_i == OPC_W'(OP_ST)) t1_addr_o = E_MEM;
        else if (opcode_i == OPC_W'(OP_ALU))                        t1_addr_o = E_ALU;
        else if (opcode_i == OPC_W'(OP_BR))                         t1_addr_o = E_BR;
        else if (opcode_i == OPC_W'(OP_JMP))                        t1_addr_o = E_JMP;
        else                                                        t1_hit_o  = 1'b0;
    end

    // Purpose: table 2 splits the load tail from the store tail.
    always_comb begin
        t2_hit_o  = 1'b1;
        t2_addr_o = '0;
        if (opcode_i == OPC_W'(OP_LD))      t2_addr_o = E_LD;
        else if (opcode_i == OPC_W'(OP_ST)) t2_addr_o = E_ST;
        else                                t2_hit_o  = 1'b0;
    end

endmodule

// File: rtl/ucode_next.sv
// Next-address select: applies the microword's sequencing code. Assumes
// a table miss must send control back to fetch and be flagged.
module ucode_next
    import ucode_pkg::*;
#(
    parameter int UA_W = 4
) (
    input  nxt_f_e          nxt_i,
    input  logic [UA_W-1:0] upc_i,
    input  logic [UA_W-1:0] t1_addr_i,
    input  logic            t1_hit_i,
    input  logic [UA_W-1:0] t2_addr_i,
    input  logic            t2_hit_i,
    output logic [UA_W-1:0] next_o,
    output logic            miss_o
);

    localparam logic [UA_W-1:0] FETCH_ADDR = '0;

    // Purpose: choose increment, fetch or a table entry.
    always_comb begin
        miss_o = 1'b0;
        next_o = FETCH_ADDR;
        case (nxt_i)
            NXT_INC:   next_o = upc_i + UA_W'(1);
            NXT_FETCH: next_o = FETCH_ADDR;
            NXT_TBL1: begin
                miss_o = !t1_hit_i;
                next_o = t1_hit_i ? t1_addr_i : FETCH_ADDR;
            end
            NXT_TBL2: begin
                miss_o = !t2_hit_i;
                next_o = t2_hit_i ? t2_addr_i : FETCH_ADDR;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ucode_decode.sv
// Field decoder: expands the encoded fields into individual strobes and
// selects. Assumes blank fields give zero strobes and zero selects.
module ucode_decode
    import ucode_pkg::*;
(
    input  uword_t      word_i,
    output logic [1:0]  alu_op_o,
    output logic        alu_src_a_o,
    output logic [1:0]  alu_src_b_o,
    output logic        rf_read_o,
    output logic        rf_write_o,
    output logic        rf_wdata_sel_o,
    output logic        mem_read_o,
    output logic        mem_write_o,
    output logic        mem_addr_sel_o,
    output logic        ir_write_o,
    output logic        pc_write_o,
    output logic        pc_write_cond_o,
    output logic [1:0]  pc_src_o
);

    // Purpose: ALU operation and operand selects pass straight through.
    always_comb begin
        alu_op_o    = word_i.alu;
        alu_src_a_o = word_i.opa;
        alu_src_b_o = word_i.opb;
    end

    // Purpose: register-file field to read/write strobes and data select.
    always_comb begin
        rf_read_o      = (word_i.rfc == RFC_READ);
        rf_write_o     = (word_i.rfc == RFC_WR_ALU) || (word_i.rfc == RFC_WR_MEM);
        rf_wdata_sel_o = (word_i.rfc == RFC_WR_MEM);
    end

    // Purpose: memory field to strobes, address select and IR load.
    always_comb begin
        mem_read_o     = (word_i.memc == MEMC_RD_PC) || (word_i.memc == MEMC_RD_ALU);
        mem_write_o    = (word_i.memc == MEMC_WR_ALU);
        mem_addr_sel_o = (word_i.memc == MEMC_RD_ALU) || (word_i.memc == MEMC_WR_ALU);
        ir_write_o     = (word_i.memc == MEMC_RD_PC);
    end

    // Purpose: PC field to write strobes and source select.
    always_comb begin
        pc_write_o      = (word_i.pcc == PCC_ALU) || (word_i.pcc == PCC_JUMP);
        pc_write_cond_o = (word_i.pcc == PCC_COND);
        case (word_i.pcc)
            PCC_COND: pc_src_o = 2'b01;
            PCC_JUMP: pc_src_o = 2'b10;
            default:  pc_src_o = 2'b00;
        endcase
    end

endmodule

// File: rtl/ucode_sequencer.sv
// Top: microprogram counter plus store, dispatch, next-address and
// decode stages. Controls are combinational from the counter and opcode;
// the counter advances on each rising edge.
module ucode_sequencer
    import ucode_pkg::*;
#(
    parameter int OPC_W = 6,
    parameter int UA_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode_i,
    output logic [UA_W-1:0]  upc_o,
    output logic [1:0]       alu_op_o,
    output logic             alu_src_a_o,
    output logic [1:0]       alu_src_b_o,
    output logic             rf_read_o,
    output logic             rf_write_o,
    output logic             rf_wdata_sel_o,
    output logic             mem_read_o,
    output logic             mem_write_o,
    output logic             mem_addr_sel_o,
    output logic             ir_write_o,
    output logic             pc_write_o,
    output logic             pc_write_cond_o,
    output logic [1:0]       pc_src_o,
    output logic             illegal_opcode_o
);

    uword_t          cur_word;
    logic [UA_W-1:0] upc_q;
    logic [UA_W-1:0] upc_next;
    logic [UA_W-1:0] t1_addr;
    logic [UA_W-1:0] t2_addr;
    logic            t1_hit;
    logic            t2_hit;

    // Purpose: microprogram counter with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= '0;
        else        upc_q <= upc_next;
    end

    assign upc_o = upc_q;

    ucode_store #(.UA_W(UA_W)) u_store (
        .addr_i (upc_q),
        .word_o (cur_word)
    );

    ucode_dispatch #(.OPC_W(OPC_W), .UA_W(UA_W)) u_disp (
        .opcode_i  (opcode_i),
        .t1_addr_o (t1_addr),
        .t1_hit_o  (t1_hit),
        .t2_addr_o (t2_addr),
        .t2_hit_o  (t2_hit)
    );

    ucode_next #(.UA_W(UA_W)) u_next (
        .nxt_i     (cur_word.nxt),
        .upc_i     (upc_q),
        .t1_addr_i (t1_addr),
        .t1_hit_i  (t1_hit),
        .t2_addr_i (t2_addr),
        .t2_hit_i  (t2_hit),
        .next_o    (upc_next),
        .miss_o    (illegal_opcode_o)
    );

    ucode_decode u_dec (
        .word_i          (cur_word),
        .alu_op_o        (alu_op_o),
        .alu_src_a_o     (alu_src_a_o),
        .alu_src_b_o     (alu_src_b_o),
        .rf_read_o       (rf_read_o),
        .rf_write_o      (rf_write_o),
        .rf_wdata_sel_o  (rf_wdata_sel_o),
        .mem_read_o      (mem_read_o),
        .mem_write_o     (mem_write_o),
        .mem_addr_sel_o  (mem_addr_sel_o),
        .ir_write_o      (ir_write_o),
        .pc_write_o      (pc_write_o),
        .pc_write_cond_o (pc_write_cond_o),
        .pc_src_o        (pc_src_o)
    );

endmodule

// File: rtl/ucode_sequencer_chk.sv
// Checker: temporal rules of the sequencer, bound to the top.
module ucode_sequencer_chk #(
    parameter int UA_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [UA_W-1:0] upc_o,
    input logic            rf_read_o,
    input logic            rf_write_o,
    input logic            mem_read_o,
    input logic            mem_write_o,
    input logic            pc_write_o,
    input logic            pc_write_cond_o,
    input logic            illegal_opcode_o
);

    AST_RESET_TO_FETCH: assert property (@(posedge clk) !rst_n |=> upc_o == '0); // R1
    AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        upc_o == UA_W'(0) |=> upc_o == UA_W'(1)); // R2
    AST_LOAD_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        upc_o == UA_W'(3) |=> upc_o == UA_W'(4)); // R5
    AST_ALU_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        upc_o == UA_W'(6) |=> upc_o == UA_W'(7)); // R7
    AST_TAILS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_o == UA_W'(4) || upc_o == UA_W'(5) || upc_o == UA_W'(7) ||
         upc_o == UA_W'(8) || upc_o == UA_W'(9)) |=> upc_o == '0); // R6
    AST_MISS_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_opcode_o |=> upc_o == '0); // R10
    AST_MISS_ONLY_IN_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_opcode_o |-> (upc_o == UA_W'(1) || upc_o == UA_W'(2))); // R10
    AST_UPC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upc_o < UA_W'(10)); // R3
    AST_RF_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_read_o && rf_write_o)); // R11
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_read_o && mem_write_o)); // R11
    AST_PC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_write_o && pc_write_cond_o)); // R11

endmodule

bind ucode_sequencer ucode_sequencer_chk #(.UA_W(UA_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .upc_o            (upc_o),
    .rf_read_o        (rf_read_o),
    .rf_write_o       (rf_write_o),
    .mem_read_o       (mem_read_o),
    .mem_write_o      (mem_write_o),
    .pc_write_o       (pc_write_o),
    .pc_write_cond_o  (pc_write_cond_o),
    .illegal_opcode_o (illegal_opcode_o)
);

// File: tb/test_ucode_sequencer.sv
// Bench: behavioural reference of the microprogram, compared each cycle.
`timescale 1ns/1ps
module test_ucode_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode_i = 6'h3F;
    logic [3:0] upc_o;
    logic [1:0] alu_op_o, alu_src_b_o, pc_src_o;
    logic       alu_src_a_o, rf_read_o, rf_write_o, rf_wdata_sel_o;
    logic       mem_read_o, mem_write_o, mem_addr_sel_o, ir_write_o;
    logic       pc_write_o, pc_write_cond_o, illegal_opcode_o;

    int n_checks = 0;
    int n_errors = 0;
    int exp_upc  = 0;
    int junk     = 7;

    always #10 clk = ~clk;

    ucode_sequencer i_ucode_sequencer (
        .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .upc_o(upc_o),
        .alu_op_o(alu_op_o), .alu_src_a_o(alu_src_a_o), .alu_src_b_o(alu_src_b_o),
        .rf_read_o(rf_read_o), .rf_write_o(rf_write_o), .rf_wdata_sel_o(rf_wdata_sel_o),
        .mem_read_o(mem_read_o), .mem_write_o(mem_write_o), .mem_addr_sel_o(mem_addr_sel_o),
        .ir_write_o(ir_write_o), .pc_write_o(pc_write_o), .pc_write_cond_o(pc_write_cond_o),
        .pc_src_o(pc_src_o), .illegal_opcode_o(illegal_opcode_o)
    );

    // Expected control vector: {alu,srcA,srcB,rfR,rfW,rfSel,mR,mW,mSel,ir,pcW,pcC,pcSrc}
    function automatic logic [16:0] ref_ctrl(int a);
        case (a)
            0: return {2'b00, 1'b0, 2'b01, 3'b000, 3'b100, 1'b1, 2'b10, 2'b00};
            1: return {2'b00, 1'b0, 2'b11, 3'b100, 3'b000, 1'b0, 2'b00, 2'b00};
            2: return {2'b00, 1'b1, 2'b10, 3'b000, 3'b000, 1'b0, 2'b00, 2'b00};
            3: return {2'b00, 1'b0, 2'b00, 3'b000, 3'b101, 1'b0, 2'b00, 2'b00};
            4: return {2'b00, 1'b0, 2'b00, 3'b011, 3'b000, 1'b0, 2'b00, 2'b00};
            5: return {2'b00, 1'b0, 2'b00, 3'b000, 3'b011, 1'b0, 2'b00, 2'b00};
            6: return {2'b10, 1'b1, 2'b00, 3'b000, 3'b000, 1'b0, 2'b00, 2'b00};
            7: return {2'b00, 1'b0, 2'b00, 3'b010, 3'b000, 1'b0, 2'b00, 2'b00};
            8: return {2'b01, 1'b1, 2'b00, 3'b000, 3'b000, 1'b0, 2'b01, 2'b01};
            9: return {2'b00, 1'b0, 2'b00, 3'b000, 3'b000, 1'b0, 2'b10, 2'b10};
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (a)
            0: return "R2"; 1: return "R3"; 2: return "R4";
            3, 4: return "R5"; 5: return "R6"; 6, 7: return "R7";
            8: return "R8"; default: return "R9";
        endcase
    endfunction

    // Reference next address and miss flag for the current opcode.
    function automatic int ref_next(int a, logic [5:0] op, output bit miss);
        miss = 1'b0;
        case (a)
            0, 3, 6: return a + 1;
            1: begin
                if (op == 6'h23 || op == 6'h2B) return 2;
                if (op == 6'h00) return 6;
                if (op == 6'h04) return 8;
                if (op == 6'h02) return 9;
                miss = 1'b1; return 0;
            end
            2: begin
                if (op == 6'h23) return 3;
                if (op == 6'h2B) return 5;
                miss = 1'b1; return 0;
            end
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (upc %0d)", req, act, exp, exp_upc);
        end
    endtask

    // One cycle: drive opcode, compare everything, advance the model.
    task automatic step(logic [5:0] op1, logic [5:0] op2, bit do_rst);
        bit miss;
        int nxt;
        @(negedge clk);
        junk = (junk * 13 + 5) % 64;
        opcode_i = (exp_upc == 1) ? op1 : (exp_upc == 2) ? op2 : 6'(junk);
        rst_n = !do_rst;
        #1;
        nxt = ref_next(exp_upc, opcode_i, miss);
        check("R10 upc", 32'(upc_o), 32'(exp_upc));
        check(req_of(exp_upc), 32'({alu_op_o, alu_src_a_o, alu_src_b_o, rf_read_o, rf_write_o,
              rf_wdata_sel_o, mem_read_o, mem_write_o, mem_addr_sel_o, ir_write_o,
              pc_write_o, pc_write_cond_o, pc_src_o}), 32'(ref_ctrl(exp_upc)));
        check("R10 illegal", 32'(illegal_opcode_o), 32'(miss));
        exp_upc = do_rst ? 0 : nxt;
    endtask

    // Run one instruction from fetch back to fetch.
    task automatic run_instr(logic [5:0] op1, logic [5:0] op2);
        step(op1, op2, 1'b0);
        while (exp_upc != 0) step(op1, op2, 1'b0);
    endtask

    initial begin
        #200000000;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        // R1: hold reset for two edges, then check the fetch word.
        step(6'h00, 6'h00, 1'b1);
        step(6'h00, 6'h00, 1'b1);
        run_instr(6'h23, 6'h23);   // load: R3 R4 R5
        run_instr(6'h2B, 6'h2B);   // store: R6
        run_instr(6'h00, 6'h00);   // R-type: R7
        run_instr(6'h04, 6'h04);   // branch: R8
        run_instr(6'h02, 6'h02);   // jump: R9
        run_instr(6'h3F, 6'h00);   // table-1 miss: R10
        run_instr(6'h23, 6'h00);   // table-2 miss: R10
        run_instr(6'h2B, 6'h04);   // table-2 miss via store path: R10
        run_instr(6'h11, 6'h23);   // table-1 miss, other code: R10
        // R1: reset in the middle of a load tail.
        step(6'h23, 6'h23, 1'b0);
        step(6'h23, 6'h23, 1'b0);
        step(6'h23, 6'h23, 1'b0);
        step(6'h23, 6'h23, 1'b1);
        check("R1 reset mid-run", 32'(exp_upc), 32'd0);
        run_instr(6'h00, 6'h00);
        run_instr(6'h23, 6'h2B);   // table 2 reads the opcode in its own cycle
        step(6'h00, 6'h00, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule